// File: doc/BRIEF.md
# GPIO Edge and Level Interrupt Unit

This block watches 32 general-purpose input pins and turns pin activity into interrupt requests. Each pin is brought into the clock domain through a two-stage synchronizer. From there it is handled by a per-pin detector that runs in one of three modes:

- **Level:** an active-high or active-low level is copied into the status bit every cycle.
- **Edge, latched:** a selected rising and/or falling transition sets the status bit, which stays set until software clears it.
- **Edge, pass-through:** a selected transition appears in the status bit for exactly one cycle.

Configuration and status are reached over a 16-bit register bus. Every function has a low register for pins 0 to 15 and a high register for pins 16 to 31. Status bits are cleared by writing 1s to them. A per-pin enable gates status into a single combined interrupt output. A priority encoder names the lowest-numbered pin whose enabled status bit is set. When no enabled bit is pending it raises a "no source" flag instead.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset all status, enable, type, polarity, hold and edge-select bits are 0, `irq_o` is 0 and `src_none_o` is 1.
- R2: Byte-addressed 16-bit registers, low half (pins 0-15) at the first offset and high half (pins 16-31) at offset+2. Status 0x08/0x0A, enable 0x0C/0x0E, type 0x10/0x12, polarity 0x14/0x16, hold 0x18/0x1A, falling select 0x20/0x22, rising select 0x24/0x26. Configuration registers read back what was written; any other address reads 0 and writes to it have no effect.
- R3: A pin change reaches the status register on the third rising clock edge after it is applied (two synchronizer stages plus the status flop).
- R4: With type bit 0 (level mode) the status bit follows the synchronized pin each cycle. Polarity bit 1 means active high; polarity bit 0 means active low.
- R5: With type bit 1 and hold bit 1, a selected edge sets the status bit. The bit then stays set until it is cleared by a status write.
- R6: Writing 1 to a status bit clears a latched bit and writing 0 leaves it unchanged. If a selected edge arrives in the same cycle as the clear, the status bit stays set.
- R7: With type bit 1 and hold bit 0, each selected edge makes the status bit 1 for exactly one cycle.
- R8: In edge mode the rising-select bit enables detection of 0-to-1 transitions and the falling-select bit enables detection of 1-to-0 transitions. Both bits set detects both edges. An edge whose select bit is 0 is ignored.
- R9: `irq_o` is the OR over all pins of status AND enable. The enable bits do not affect what is captured in status.
- R10: `src_idx_o` gives the lowest pin index whose status and enable bits are both 1. Pins 0-15 therefore win over pins 16-31. `src_none_o` is 1 exactly when no such pin exists.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 32 | Asynchronous input pins |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register byte address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Combined interrupt request |
| src_idx_o | output | 5 | Lowest enabled pending pin |
| src_none_o | output | 1 | No enabled pending pin |

## Verification
The bench aims at the cycle in which a pin change first shows in status. A design with one synchronizer stage too few or too many would fail the samples taken one edge before and on the expected edge.

It also lines up an edge with a clearing write in the same cycle. A design that lets the clear win would lose that event.

Other directed cases cover the following:
- Write-0-to-status, which must not touch a latched bit.
- An unselected edge direction, which must not set status.
- The one-cycle width of a pass-through event.
- A pending pin in the low half competing with one in the high half. An encoder that scans the wrong way, or checks the high half first, would report pin 20 instead of pin 3.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam logic [ADDR_W-1:0] A_STAT_LO = 6'h08;
  localparam logic [ADDR_W-1:0] A_STAT_HI = 6'h0A;
  localparam logic [ADDR_W-1:0] A_EN_LO   = 6'h0C;
  localparam logic [ADDR_W-1:0] A_EN_HI   = 6'h0E;
  localparam logic [ADDR_W-1:0] A_TYP_LO  = 6'h10;
  localparam logic [ADDR_W-1:0] A_TYP_HI  = 6'h12;
  localparam logic [ADDR_W-1:0] A_POL_LO  = 6'h14;
  localparam logic [ADDR_W-1:0] A_POL_HI  = 6'h16;
  localparam logic [ADDR_W-1:0] A_HLD_LO  = 6'h18;
  localparam logic [ADDR_W-1:0] A_HLD_HI  = 6'h1A;
  localparam logic [ADDR_W-1:0] A_FSEL_LO = 6'h20;
  localparam logic [ADDR_W-1:0] A_FSEL_HI = 6'h22;
  localparam logic [ADDR_W-1:0] A_RSEL_LO = 6'h24;
  localparam logic [ADDR_W-1:0] A_RSEL_HI = 6'h26;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, cur_q, prev_q;

  // reset to idle-high so active-low level mode starts quiet
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '1;
      cur_q  <= '1;
      prev_q <= '1;
    end else begin
      meta_q <= d_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cur_i,
  input  logic prev_i,
  input  logic edge_mode_i,
  input  logic act_high_i,
  input  logic hold_i,
  input  logic rise_sel_i,
  input  logic fall_sel_i,
  input  logic clr_i,
  output logic stat_o
);
  logic stat_q, stat_d, edge_hit, level_hit;

  assign edge_hit  = (rise_sel_i & cur_i & ~prev_i) | (fall_sel_i & ~cur_i & prev_i);
  assign level_hit = act_high_i ? cur_i : ~cur_i;

  always_comb begin
    if (!edge_mode_i)  stat_d = level_hit;
    else if (!hold_i)  stat_d = edge_hit;
    else               stat_d = edge_hit | (stat_q & ~clr_i); // new event beats clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= 1'b0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/gpio_irq_prio.sv
module gpio_irq_prio #(
  parameter int unsigned W  = 32,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          none_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = i[IW-1:0];
    end
  end

  assign none_o = ~|req_i;
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned NPINS = 2 * DW,
  parameter int unsigned IDX_W = $clog2(NPINS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o,
  output logic [IDX_W-1:0]  src_idx_o,
  output logic              src_none_o
);
  logic [NPINS-1:0] en_q, typ_q, pol_q, hold_q, fsel_q, rsel_q;
  logic [NPINS-1:0] stat_q, clr, sync_s, sync_p, pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      typ_q  <= '0;
      pol_q  <= '0;
      hold_q <= '0;
      fsel_q <= '0;
      rsel_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_EN_LO:   en_q[DW-1:0]       <= wdata_i;
        A_EN_HI:   en_q[NPINS-1:DW]   <= wdata_i;
        A_TYP_LO:  typ_q[DW-1:0]      <= wdata_i;
        A_TYP_HI:  typ_q[NPINS-1:DW]  <= wdata_i;
        A_POL_LO:  pol_q[DW-1:0]      <= wdata_i;
        A_POL_HI:  pol_q[NPINS-1:DW]  <= wdata_i;
        A_HLD_LO:  hold_q[DW-1:0]     <= wdata_i;
        A_HLD_HI:  hold_q[NPINS-1:DW] <= wdata_i;
        A_FSEL_LO: fsel_q[DW-1:0]     <= wdata_i;
        A_FSEL_HI: fsel_q[NPINS-1:DW] <= wdata_i;
        A_RSEL_LO: rsel_q[DW-1:0]     <= wdata_i;
        A_RSEL_HI: rsel_q[NPINS-1:DW] <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    clr = '0;
    if (wr_en_i && addr_i == A_STAT_LO) clr[DW-1:0]     = wdata_i;
    if (wr_en_i && addr_i == A_STAT_HI) clr[NPINS-1:DW] = wdata_i;
  end

  always_comb begin
    case (addr_i)
      A_STAT_LO: rdata_o = stat_q[DW-1:0];
      A_STAT_HI: rdata_o = stat_q[NPINS-1:DW];
      A_EN_LO:   rdata_o = en_q[DW-1:0];
      A_EN_HI:   rdata_o = en_q[NPINS-1:DW];
      A_TYP_LO:  rdata_o = typ_q[DW-1:0];
      A_TYP_HI:  rdata_o = typ_q[NPINS-1:DW];
      A_POL_LO:  rdata_o = pol_q[DW-1:0];
      A_POL_HI:  rdata_o = pol_q[NPINS-1:DW];
      A_HLD_LO:  rdata_o = hold_q[DW-1:0];
      A_HLD_HI:  rdata_o = hold_q[NPINS-1:DW];
      A_FSEL_LO: rdata_o = fsel_q[DW-1:0];
      A_FSEL_HI: rdata_o = fsel_q[NPINS-1:DW];
      A_RSEL_LO: rdata_o = rsel_q[DW-1:0];
      A_RSEL_HI: rdata_o = rsel_q[NPINS-1:DW];
      default:   rdata_o = '0;
    endcase
  end

  gpio_irq_sync #(.W(NPINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .cur_o  (sync_s),
    .prev_o (sync_p)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_cell
    gpio_irq_cell u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cur_i       (sync_s[g]),
      .prev_i      (sync_p[g]),
      .edge_mode_i (typ_q[g]),
      .act_high_i  (pol_q[g]),
      .hold_i      (hold_q[g]),
      .rise_sel_i  (rsel_q[g]),
      .fall_sel_i  (fsel_q[g]),
      .clr_i       (clr[g]),
      .stat_o      (stat_q[g])
    );
  end

  assign pend  = stat_q & en_q;
  assign irq_o = |pend;

  gpio_irq_prio #(.W(NPINS), .IW(IDX_W)) u_prio (
    .req_i  (pend),
    .idx_o  (src_idx_o),
    .none_o (src_none_o)
  );
endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned DW    = 16,
  parameter int unsigned IDX_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic              irq_o,
  input logic [IDX_W-1:0]  src_idx_o,
  input logic              src_none_o,
  input logic [NPINS-1:0]  stat_q,
  input logic [NPINS-1:0]  en_q,
  input logic [NPINS-1:0]  typ_q,
  input logic [NPINS-1:0]  pol_q,
  input logic [NPINS-1:0]  hold_q,
  input logic [NPINS-1:0]  fsel_q,
  input logic [NPINS-1:0]  rsel_q,
  input logic [NPINS-1:0]  sync_s
);
  p_irq_none_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o != src_none_o);

  p_src_pending_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_none_o |-> (stat_q[src_idx_o] && en_q[src_idx_o]));

  p_src_lowest_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_none_o |-> ((stat_q & en_q & ((NPINS'(1) << src_idx_o) - NPINS'(1))) == '0));

  p_level_follow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!typ_q[0] && !wr_en_i) |=> stat_q[0] == $past(pol_q[0] ? sync_s[0] : ~sync_s[0]));

  p_hold_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (typ_q[0] && hold_q[0] && stat_q[0] && !wr_en_i) |=> stat_q[0]);

  p_w1c_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (typ_q[0] && hold_q[0] && !rsel_q[0] && !fsel_q[0] && wr_en_i
     && addr_i == A_STAT_LO && wdata_i[0]) |=> !stat_q[0]);
endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.NPINS(NPINS), .DW(DW), .IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .irq_o      (irq_o),
  .src_idx_o  (src_idx_o),
  .src_none_o (src_none_o),
  .stat_q     (stat_q),
  .en_q       (en_q),
  .typ_q      (typ_q),
  .pol_q      (pol_q),
  .hold_q     (hold_q),
  .fsel_q     (fsel_q),
  .rsel_q     (rsel_q),
  .sync_s     (sync_s)
);

// File: tb/gpio_irq_unit_tb.sv
module gpio_irq_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pin_i = '1;
  logic        wr_en_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;
  logic [4:0]  src_idx_o;
  logic        src_none_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  gpio_irq_unit u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (pin_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .irq_o      (irq_o),
    .src_idx_o  (src_idx_o),
    .src_none_o (src_none_o)
  );

  typedef struct packed {
    logic [5:0]  a;
    logic [15:0] d;
    logic [15:0] e;
  } vec_t;

  // register write / read-back vectors (R2)
  localparam vec_t VEC [0:13] = '{
    '{6'h0C, 16'hA5A5, 16'hA5A5},
    '{6'h0E, 16'h1234, 16'h1234},
    '{6'h10, 16'h0F0F, 16'h0F0F},
    '{6'h12, 16'hF00D, 16'hF00D},
    '{6'h14, 16'h3C3C, 16'h3C3C},
    '{6'h16, 16'h8001, 16'h8001},
    '{6'h18, 16'h5555, 16'h5555},
    '{6'h1A, 16'hAAAA, 16'hAAAA},
    '{6'h20, 16'h00FF, 16'h00FF},
    '{6'h22, 16'hFF00, 16'hFF00},
    '{6'h24, 16'h1111, 16'h1111},
    '{6'h26, 16'h2222, 16'h2222},
    '{6'h02, 16'hFFFF, 16'h0000},
    '{6'h3E, 16'hFFFF, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic set_pin(input int idx, input logic v);
    @(negedge clk_i);
    pin_i[idx] = v;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(2);

    // R1 reset state
    chk("R1 irq", irq_o, 0);
    chk("R1 none", src_none_o, 1);
    rd(6'h08, d); chk("R1 stat_lo", d, 0);
    rd(6'h0A, d); chk("R1 stat_hi", d, 0);
    rd(6'h0C, d); chk("R1 en_lo", d, 0);
    rd(6'h10, d); chk("R1 typ_lo", d, 0);
    rd(6'h14, d); chk("R1 pol_lo", d, 0);

    // R2 table walk
    for (int i = 0; i < 14; i++) begin
      wr(VEC[i].a, VEC[i].d);
      rd(VEC[i].a, d);
      chk("R2 readback", d, VEC[i].e);
    end
    for (int a = 6'h0C; a <= 6'h26; a += 2) begin
      if (a != 6'h1C && a != 6'h1E) wr(6'(a), 16'h0000);
    end
    wait_n(2);
    rd(6'h08, d); chk("R2 stat_lo clean", d, 0);
    rd(6'h0A, d); chk("R2 stat_hi clean", d, 0);

    // R3 / R4 level, active low, pin 3
    set_pin(3, 1'b0);
    wait_n(2);
    rd(6'h08, d); chk("R3 not yet", d, 0);
    wait_n(1);
    rd(6'h08, d); chk("R3 arrives", d, 16'h0008);
    wr(6'h0C, 16'h0008);
    chk("R9 irq", irq_o, 1);
    chk("R10 idx", src_idx_o, 3);
    chk("R10 none", src_none_o, 0);
    set_pin(3, 1'b1);
    wait_n(3);
    rd(6'h08, d); chk("R4 low released", d, 0);
    wr(6'h14, 16'h0008);
    wait_n(1);
    rd(6'h08, d); chk("R4 active high", d, 16'h0008);
    wr(6'h14, 16'h0000);
    wait_n(1);
    rd(6'h08, d); chk("R4 back low", d, 0);
    chk("R9 irq clear", irq_o, 0);

    // R5 / R8 edge hold, pin 20 (high bit 4), rising only
    wr(6'h12, 16'h0010);
    wr(6'h1A, 16'h0010);
    wr(6'h26, 16'h0010);
    wr(6'h0E, 16'h0010);
    set_pin(20, 1'b0);
    wait_n(4);
    rd(6'h0A, d); chk("R8 fall ignored", d, 0);
    set_pin(20, 1'b1);
    wait_n(3);
    rd(6'h0A, d); chk("R5 latched", d, 16'h0010);
    chk("R10 idx high", src_idx_o, 20);
    wait_n(5);
    rd(6'h0A, d); chk("R5 held", d, 16'h0010);
    set_pin(3, 1'b0);
    wait_n(3);
    chk("R10 low half first", src_idx_o, 3);
    set_pin(3, 1'b1);
    wait_n(3);
    wr(6'h0A, 16'h0000);
    rd(6'h0A, d); chk("R6 write0 keeps", d, 16'h0010);
    wr(6'h0A, 16'h0010);
    rd(6'h0A, d); chk("R6 write1 clears", d, 0);
    chk("R10 none after clear", src_none_o, 1);

    // R8 falling only, R9 enable off
    wr(6'h0E, 16'h0000);
    wr(6'h22, 16'h0010);
    wr(6'h26, 16'h0000);
    set_pin(20, 1'b0);
    wait_n(3);
    rd(6'h0A, d); chk("R8 fall seen", d, 16'h0010);
    chk("R9 disabled no irq", irq_o, 0);

    // R6 edge wins over same-cycle clear (both edges selected)
    wr(6'h26, 16'h0010);
    set_pin(20, 1'b1);
    wait_n(2);
    wr_en_i = 1'b1; addr_i = 6'h0A; wdata_i = 16'h0010;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    rd(6'h0A, d); chk("R6 edge beats clear", d, 16'h0010);
    wr(6'h0A, 16'h0010);
    rd(6'h0A, d); chk("R6 cleared", d, 0);

    // R7 pass-through, rising only
    wr(6'h1A, 16'h0000);
    wr(6'h22, 16'h0000);
    set_pin(20, 1'b0);
    wait_n(3);
    rd(6'h0A, d); chk("R7 fall quiet", d, 0);
    set_pin(20, 1'b1);
    wait_n(2);
    rd(6'h0A, d); chk("R7 before", d, 0);
    wait_n(1);
    rd(6'h0A, d); chk("R7 pulse", d, 16'h0010);
    wait_n(1);
    rd(6'h0A, d); chk("R7 one cycle", d, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule